// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout Interrupt

This block is a bus-mapped watchdog built from five 16-bit registers: control, service, reset cause, interrupt control and miscellaneous control. Once software enables it, a down-counter loaded from an 8-bit timeout field counts half-second ticks. A programmable prescaler derives the ticks from the system clock. Software keeps the system alive by writing two fixed service words in order, and that sequence is the only thing that reloads the counter. If the counter runs out, the block records a timeout cause and pulses a reset request towards the chip's reset controller.

An optional pretimeout stage, chosen by a parameter, compares the remaining count against a programmable value. It raises a level interrupt that many ticks before expiry, so software gets a last chance to act. The configuration is protected against runaway code in three ways. The timeout field and the interrupt settings freeze after their first write. The enable bit cannot be cleared once set. Two active-low command bits in the control register request a reset immediately: a software reset, which is also recorded as a cause, and an external reset assert.

Register byte offsets: control 0x0, service 0x2, reset cause 0x4, interrupt control 0x6, miscellaneous 0x8. Accesses are 16 bits wide at even addresses only.

Top module: `wdog_pretimeout`

## Requirements
- R1: After reset the registers read: control 0x0006, service 0x0000, reset cause 0x0000, interrupt control 0x0004 (the default pretimeout count), miscellaneous 0x0001. Both outputs are low.
- R2: Control bits 15:8 hold the timeout value N and bit 0 is the enable. Writing enable=1 loads N+1 ticks of TICK_DIV clocks each. On expiry, reset_req is high for exactly one cycle, (N+1)*TICK_DIV cycles after the enabling write, and the reset cause reads 0x0002 (bit 1 = timeout).
- R3: A service-register write of 0xAAAA reloads the counter to N+1 ticks only if the previous service-register write was 0x5555. Any other order, including a different word in between, leaves the count running.
- R4: The enable bit (control bit 0) is sticky: writing it 0 after it was 1 leaves it reading 1, and the countdown continues.
- R5: The timeout field is write-once. The first control write sets it, and later writes leave it unchanged.
- R6: Writing control bit 1 (software reset, active low) as 0 pulses reset_req in the following cycle and sets the reset cause to 0x0001. The bit always reads 1. A later timeout replaces the cause with 0x0002.
- R7: Writing control bit 2 (external reset assert, active low) as 0 pulses reset_req in the following cycle and leaves the cause unchanged. The bit reads back as written.
- R8: Interrupt control holds the interrupt enable in bit 15, the status in bit 14 and the pretimeout count P in bits 7:0. When enabled and armed, status and irq go high when the remaining count reaches P. That happens (N+1-P)*TICK_DIV cycles after the load. They stay high until a write with bit 14 set clears them.
- R9: The pretimeout stage arms only if the remaining count is strictly greater than P, checked at a load or an interrupt-control write. Otherwise irq stays low.
- R10: The interrupt enable and P are write-once. The status clear still works after the lock.
- R11: The reset-cause register ignores writes. In the miscellaneous register only bit 0 (power-down enable) is writable.
- R12: A write to an odd byte address has no effect, and a read at an odd address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Pretimeout interrupt, level |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The bench sweeps the timeout value and every pretimeout value against it. A design that has the reload off by one tick, or the prescaler phase off by one cycle, moves the reset pulse or the interrupt by a measurable number of cycles. With P equal to or above N+1, a design that arms without the strict comparison fires at once or at the very first tick. The service sequence is tried in the right order, in reverse, and with a stray word in between. A reload that only looks at the last word would wrongly postpone expiry. The bench also writes to the locked fields and the sticky enable after their first write. A design that lets a later write through would change the readback, or would stop the reset pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int REG_W   = 16;
    localparam int TMO_W   = 8;
    localparam int CNT_W   = TMO_W + 1;
    localparam int IDX_W   = 3;

    // register word indices (byte offset / 2)
    localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_SVC   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CAUSE = 3'd2;
    localparam logic [IDX_W-1:0] IDX_ICR   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_MISC  = 3'd4;

    // control register fields
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_SW_BIT  = 1;
    localparam int CTL_EXT_BIT = 2;
    localparam int CTL_TMO_LSB = 8;

    // interrupt control fields
    localparam int ICR_EN_BIT = 15;
    localparam int ICR_ST_BIT = 14;

    // service words
    localparam logic [REG_W-1:0] SVC_FIRST  = 16'h5555;
    localparam logic [REG_W-1:0] SVC_SECOND = 16'hAAAA;

    // reset cause encodings (one-hot, last cause wins)
    localparam logic [1:0] CAUSE_NONE = 2'b00;
    localparam logic [1:0] CAUSE_SW   = 2'b01;
    localparam logic [1:0] CAUSE_TOUT = 2'b10;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic             en;
        logic             ext;
        logic             ctrl_lock;
        logic [REG_W-1:0] svc;
        logic [1:0]       cause;
        logic             pre_en;
        logic [TMO_W-1:0] pre;
        logic             status;
        logic             armed;
        logic             icr_lock;
        logic             pwrdn;
        logic             rst_req;
    } wdog_state_t;

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] presc_d, presc_q;

    assign tick = run && (presc_q == LAST);

    always_comb begin
        if (restart || !run || tick) presc_d = '0;
        else                         presc_d = presc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end
endmodule

// File: rtl/wdog_downcounter.sv
module wdog_downcounter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);
    logic [CNT_W-1:0] count_d;

    assign expire = tick && (count_q == CNT_W'(1));

    always_comb begin
        if (load)                          count_d = load_val;
        else if (tick && count_q != '0)    count_d = count_q - 1'b1;
        else                               count_d = count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end
endmodule

// File: rtl/wdog_pretimeout.sv
module wdog_pretimeout
    import wdog_pkg::*;
#(
    parameter int          CLK_HZ         = 100_000_000,
    parameter int          TICK_HZ        = 2,
    parameter int          ADDR_W         = 4,
    parameter bit          HAS_PRETIMEOUT = 1'b1,
    parameter logic [7:0]  DEF_PRE        = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq,
    output logic              reset_req
);
    localparam int TICK_DIV = CLK_HZ / TICK_HZ;

    wdog_state_t st_d, st_q;

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count_q;
    logic             tick;
    logic             expire;
    logic             wr_ok;
    logic [IDX_W-1:0] idx;
    logic             pre_hit;

    assign idx   = bus_addr[IDX_W:1];
    assign wr_ok = bus_we && !bus_addr[0];

    wdog_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (count_q != '0),
        .restart (load),
        .tick    (tick)
    );

    wdog_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick),
        .count_q  (count_q),
        .expire   (expire)
    );

    assign pre_hit = tick && st_q.armed && ((count_q - CNT_W'(1)) == CNT_W'(st_q.pre));

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        load         = 1'b0;

        if (wr_ok) begin
            case (idx)
                IDX_CTRL: begin
                    if (!st_q.ctrl_lock) st_d.tmo = bus_wdata[CTL_TMO_LSB +: TMO_W];
                    st_d.ctrl_lock = 1'b1;
                    st_d.ext       = bus_wdata[CTL_EXT_BIT];
                    if (bus_wdata[CTL_EN_BIT] && !st_q.en) begin
                        st_d.en = 1'b1;
                        load    = 1'b1;
                    end
                    if (!bus_wdata[CTL_SW_BIT]) begin
                        st_d.cause   = CAUSE_SW;
                        st_d.rst_req = 1'b1;
                    end
                    if (!bus_wdata[CTL_EXT_BIT]) st_d.rst_req = 1'b1;
                end
                IDX_SVC: begin
                    if (st_q.en && st_q.svc == SVC_FIRST && bus_wdata == SVC_SECOND)
                        load = 1'b1;
                    st_d.svc = bus_wdata;
                end
                IDX_ICR: begin
                    if (HAS_PRETIMEOUT) begin
                        if (!st_q.icr_lock) begin
                            st_d.pre_en = bus_wdata[ICR_EN_BIT];
                            st_d.pre    = bus_wdata[TMO_W-1:0];
                        end
                        st_d.icr_lock = 1'b1;
                        if (bus_wdata[ICR_ST_BIT]) st_d.status = 1'b0;
                        st_d.armed = st_d.pre_en && (count_q > CNT_W'(st_d.pre));
                    end
                end
                IDX_MISC: st_d.pwrdn = bus_wdata[0];
                default: ;
            endcase
        end

        load_val = CNT_W'(st_d.tmo) + CNT_W'(1);

        if (load) begin
            st_d.armed = st_d.pre_en && (load_val > CNT_W'(st_d.pre));
        end else begin
            if (pre_hit) begin
                st_d.status = 1'b1;
                st_d.armed  = 1'b0;
            end
            if (expire) begin
                st_d.cause   = CAUSE_TOUT;
                st_d.rst_req = 1'b1;
                st_d.armed   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ext       <= 1'b1;
            st_q.pre       <= DEF_PRE;
            st_q.pwrdn     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[0]) begin
            case (idx)
                IDX_CTRL:  bus_rdata = {st_q.tmo, 5'b0, st_q.ext, 1'b1, st_q.en};
                IDX_SVC:   bus_rdata = st_q.svc;
                IDX_CAUSE: bus_rdata = {14'b0, st_q.cause};
                IDX_ICR:   bus_rdata = HAS_PRETIMEOUT ?
                                       {st_q.pre_en, st_q.status, 6'b0, st_q.pre} : 16'h0;
                IDX_MISC:  bus_rdata = {15'b0, st_q.pwrdn};
                default:   bus_rdata = '0;
            endcase
        end
    end

    generate
        if (HAS_PRETIMEOUT) begin : g_pre
            assign irq = st_q.status;
        end else begin : g_nopre
            assign irq = 1'b0;
        end
    endgenerate

    assign reset_req = st_q.rst_req;

endmodule

module wdog_pretimeout_chk
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              irq,
    input logic              reset_req,
    input logic              en_q,
    input logic [TMO_W-1:0]  pre_q,
    input logic              icr_lock_q,
    input logic [1:0]        cause_q,
    input logic [CNT_W-1:0]  count_q
);
    logic ctrl_wr, svc_wr, icr_wr;
    assign ctrl_wr = bus_we && !bus_addr[0] && bus_addr[IDX_W:1] == IDX_CTRL;
    assign svc_wr  = bus_we && !bus_addr[0] && bus_addr[IDX_W:1] == IDX_SVC;
    assign icr_wr  = bus_we && !bus_addr[0] && bus_addr[IDX_W:1] == IDX_ICR;

    // R6
    sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[CTL_SW_BIT]) |=> (reset_req && cause_q == CAUSE_SW));

    // R2
    tout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !$past(ctrl_wr)) |-> (cause_q == CAUSE_TOUT));

    // R3
    reload_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q > $past(count_q)) |-> $past(ctrl_wr || svc_wr));

    // R4
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(icr_wr && bus_wdata[ICR_ST_BIT]));

    // R10
    pre_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        icr_lock_q |=> $stable(pre_q));

    // R12
    odd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[0] |-> (bus_rdata == 16'h0));
endmodule

bind wdog_pretimeout wdog_pretimeout_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .reset_req  (reset_req),
    .en_q       (st_q.en),
    .pre_q      (st_q.pre),
    .icr_lock_q (st_q.icr_lock),
    .cause_q    (st_q.cause),
    .count_q    (count_q)
);

// File: tb/wdog_pretimeout_bench.sv
module wdog_pretimeout_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 16;
    localparam int TICK_HZ    = 2;
    localparam int D          = CLK_HZ / TICK_HZ;
    localparam int ADDR_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              irq;
    logic              reset_req;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int last_wr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_pretimeout #(
        .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .ADDR_W(ADDR_W),
        .HAS_PRETIMEOUT(1'b1), .DEF_PRE(8'h04)
    ) u_wdog_pretimeout (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .reset_req(reset_req)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0;
        last_wr = cyc;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic expect_pulse(input string tag, input int target);
        wait_until(target - 1);
        chk({tag, " before"}, {15'b0, reset_req}, 16'h0);
        wait_until(target);
        chk({tag, " pulse"}, {15'b0, reset_req}, 16'h1);
        wait_until(target + 1);
        chk({tag, " after"}, {15'b0, reset_req}, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int p0, p1;

        // R1 reset values
        do_reset();
        rd(4'h0, v); chk("R1 ctrl", v, 16'h0006);
        rd(4'h2, v); chk("R1 svc", v, 16'h0000);
        rd(4'h4, v); chk("R1 cause", v, 16'h0000);
        rd(4'h6, v); chk("R1 icr", v, 16'h0004);
        rd(4'h8, v); chk("R1 misc", v, 16'h0001);
        chk("R1 outputs", {14'b0, irq, reset_req}, 16'h0);

        // R2 expiry sweep over timeout values
        for (int n = 0; n < 8; n++) begin
            do_reset();
            wr(4'h0, 16'(n << 8) | 16'h0007);
            p0 = last_wr;
            expect_pulse("R2 expiry", p0 + (n + 1) * D);
            rd(4'h4, v); chk("R2 cause", v, 16'h0002);
        end

        // R3 correct service sequence reloads
        do_reset();
        wr(4'h0, 16'h0307); p0 = last_wr;
        wait_until(p0 + 20);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA); p1 = last_wr;
        wait_until(p0 + 4 * D);
        chk("R3 no expiry after reload", {15'b0, reset_req}, 16'h0);
        expect_pulse("R3 reloaded", p1 + 4 * D);

        // R3 reversed order does not reload
        do_reset();
        wr(4'h0, 16'h0307); p0 = last_wr;
        wait_until(p0 + 10);
        wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555);
        expect_pulse("R3 reversed", p0 + 4 * D);

        // R3 stray word between the two does not reload
        do_reset();
        wr(4'h0, 16'h0307); p0 = last_wr;
        wait_until(p0 + 10);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        expect_pulse("R3 interleaved", p0 + 4 * D);

        // R5 timeout field write-once, R4 enable sticky
        do_reset();
        wr(4'h0, 16'h0206);
        rd(4'h0, v); chk("R5 first write", v, 16'h0206);
        wr(4'h0, 16'h0707); p0 = last_wr;
        rd(4'h0, v); chk("R5 locked field", v, 16'h0207);
        wr(4'h0, 16'h0006);
        rd(4'h0, v); chk("R4 enable sticky", v, 16'h0207);
        expect_pulse("R4 R5 expiry with locked N", p0 + 3 * D);

        // R6 software reset
        do_reset();
        wr(4'h0, 16'h0004); p0 = last_wr;
        chk("R6 pulse", {15'b0, reset_req}, 16'h1);
        rd(4'h4, v); chk("R6 cause", v, 16'h0001);
        rd(4'h0, v); chk("R6 sw bit reads 1", v, 16'h0006);
        wait_until(p0 + 1);
        chk("R6 single pulse", {15'b0, reset_req}, 16'h0);
        wr(4'h0, 16'h0007); p0 = last_wr;
        expect_pulse("R6 later timeout", p0 + D);
        rd(4'h4, v); chk("R6 cause replaced", v, 16'h0002);

        // R7 external reset assert
        do_reset();
        wr(4'h0, 16'h0002); p0 = last_wr;
        chk("R7 pulse", {15'b0, reset_req}, 16'h1);
        rd(4'h0, v); chk("R7 readback", v, 16'h0002);
        rd(4'h4, v); chk("R7 cause unchanged", v, 16'h0000);
        wr(4'h0, 16'h0006);
        chk("R7 no pulse on 1", {15'b0, reset_req}, 16'h0);

        // R8 R10 pretimeout sweep
        for (int n = 0; n < 6; n++) begin
            for (int p = 0; p < 8; p++) begin
                do_reset();
                wr(4'h6, 16'h8000 | 16'(p));
                wr(4'h0, 16'(n << 8) | 16'h0007); p0 = last_wr;
                if (p < n + 1) begin
                    wait_until(p0 + (n + 1 - p) * D - 1);
                    chk("R8 irq before", {15'b0, irq}, 16'h0);
                    wait_until(p0 + (n + 1 - p) * D);
                    chk("R8 irq at pretimeout", {15'b0, irq}, 16'h1);
                    wait_until(p0 + (n + 1) * D + 1);
                    chk("R8 irq held", {15'b0, irq}, 16'h1);
                    rd(4'h6, v); chk("R8 status", v, 16'hC000 | 16'(p));
                    wr(4'h6, 16'h4007);
                    chk("R8 W1C clears irq", {15'b0, irq}, 16'h0);
                    rd(4'h6, v); chk("R10 fields locked", v, 16'h8000 | 16'(p));
                end else begin
                    wait_until(p0 + (n + 1) * D + 1);
                    chk("R9 never armed", {15'b0, irq}, 16'h0);
                end
            end
        end

        // R9 late write with count not above P
        do_reset();
        wr(4'h0, 16'h0507); p0 = last_wr;
        wait_until(p0 + 4 * D + 1);
        wr(4'h6, 16'h8003);
        wait_until(p0 + 6 * D + 2);
        chk("R9 count below P", {15'b0, irq}, 16'h0);

        // R9 late write with count above P
        do_reset();
        wr(4'h0, 16'h0507); p0 = last_wr;
        wait_until(p0 + 4 * D + 1);
        wr(4'h6, 16'h8001);
        wait_until(p0 + 5 * D - 1);
        chk("R9 armed late before", {15'b0, irq}, 16'h0);
        wait_until(p0 + 5 * D);
        chk("R9 armed late fires", {15'b0, irq}, 16'h1);

        // R11 read-only cause, misc write mask
        do_reset();
        wr(4'h4, 16'hFFFF);
        rd(4'h4, v); chk("R11 cause read-only", v, 16'h0000);
        wr(4'h8, 16'hFFFE);
        rd(4'h8, v); chk("R11 misc clear", v, 16'h0000);
        wr(4'h8, 16'hFFFF);
        rd(4'h8, v); chk("R11 misc mask", v, 16'h0001);

        // R12 odd addresses
        do_reset();
        wr(4'h1, 16'h0000);
        chk("R12 no pulse", {15'b0, reset_req}, 16'h0);
        rd(4'h0, v); chk("R12 ctrl untouched", v, 16'h0006);
        rd(4'h1, v); chk("R12 odd read", v, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule